// File: doc/BRIEF.md
# Interface-Card EEPROM Command Mailbox

This block lets a CPU fetch identification words from the small EEPROMs on up to three interface cards. It does so through a few 16-bit registers. Software first writes a card-select code. It then writes a two-word command into the data register, and the first word carries a 6-bit byte offset. A later read of the data register returns two consecutive EEPROM bytes, packed big-end first. That response is given once: after it has been read, the data register answers 0xFFFF again until a new command is armed.

The same select register, when read, reports which card slots are populated. A second register reads back a fixed identification value. Toward the cards the block has a byte-read port. The port carries a card index and a 6-bit byte address, and the addressed card's model answers in the same cycle. The two byte fetches run one after the other in hardware. Every bus access is finished by a one-cycle ready pulse.

Top module: `eeprom_mailbox`

## Requirements
- R1: A write to offset 0x100004 stores the select value. A read of 0x100004 returns 0xFFFF with bit i cleared for every slot i (0..2) whose `slotPresent[i]` is high.
- R2: The select value 0x1700 picks card 0, 0x1D00 picks card 1 and 0x3500 picks card 2. Any other value picks no card, and then an armed command reads back 0xFFFF.
- R3: Writes to offset 0x100008 fill a two-word command in order. The second write arms the command, and the next write starts a new first word.
- R4: The byte offset is bits 5:0 of the first command word. All other bits of that word, and the whole second word, have no effect on the response.
- R5: A read of 0x100008 with an armed command, a valid card and `cardHasEeprom` high returns byte[offset] in bits 15:8 and byte[offset+1] in bits 7:0. The offset+1 address wraps within 64 bytes, so offset 63 pairs with offset 0.
- R6: Any read of 0x100008 while a command is armed disarms it, so the next read of 0x100008 returns 0xFFFF.
- R7: A read of 0x100008 returns 0xFFFF when no command is armed. It also returns 0xFFFF when the selected card has `cardHasEeprom` low.
- R8: A read of offset 0x100006 always returns 0x0004.
- R9: Writing the select register between the two command words does not restart the command buffer.
- R10: Each access is held on `regWrEn`/`regRdEn` until `regReady` pulses high for exactly one cycle. That pulse comes in the first cycle after acceptance, or in the third cycle when two EEPROM bytes are fetched.
- R11: A read of any other offset returns 0x0000, and a write to any other offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 24 | Register byte offset |
| regWrEn | input | 1 | Write request, held until ready |
| regRdEn | input | 1 | Read request, held until ready |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, valid while regReady is high |
| regReady | output | 1 | One-cycle access completion |
| slotPresent | input | 3 | Card slot populated flags |
| cardHasEeprom | input | 3 | Per-card EEPROM present flags |
| eeReq | output | 1 | EEPROM byte fetch strobe |
| eeCard | output | 2 | Card index of the fetch |
| eeAddr | output | 6 | Byte address of the fetch |
| eeData | input | 8 | Byte returned by the addressed card, same cycle |

## Verification
An arm flag or write pointer that drifts shows up at the ports when the data register is next read. The read then returns 0xFFFF where a word was due, or a word where 0xFFFF was due, and its ready pulse arrives one or three cycles after the request instead of the other. A wrong latched offset or a missing wrap puts the wrong bytes into the response at once, so the corner offsets 63 and 0 are exercised. The bench compares the ready line on every cycle of every access, so a stuck handshake or an extra fetch cycle is reported on the cycle where it differs.

// File: rtl/mb_pkg.sv
package mb_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 16;
  localparam int OFF_W     = 6;
  localparam int NUM_CARDS = 3;
  localparam int CARD_W    = $clog2(NUM_CARDS);
  localparam int BYTE_W    = 8;

  localparam logic [ADDR_W-1:0] SEL_ADDR  = 24'h100004;
  localparam logic [ADDR_W-1:0] ID_ADDR   = 24'h100006;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 24'h100008;

  localparam logic [DATA_W-1:0] ID_VALUE  = 16'h0004;
  localparam logic [DATA_W-1:0] BLANK     = 16'hFFFF;

  localparam logic [DATA_W-1:0] CARD_CODE [NUM_CARDS] = '{16'h1700, 16'h1D00, 16'h3500};

  typedef struct packed {
    logic selWr;
    logic cmdWr;
    logic fetchHi;
    logic fetchLo;
    logic latchRd;
    logic consume;
  } mbStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH_HI, ST_FETCH_LO, ST_ACK} mbState_t;
endpackage

// File: rtl/mb_ctrl.sv
module mb_ctrl
  import mb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              cmdValid,
  input  logic              cardOk,
  output mbStrobe_t         strb,
  output logic              regReady
);
  mbState_t state, nextState;

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (regWrEn) begin
          strb.selWr = (regAddr == SEL_ADDR);
          strb.cmdWr = (regAddr == DATA_ADDR);
          nextState  = ST_ACK;
        end else if (regRdEn) begin
          if (regAddr == DATA_ADDR && cmdValid && cardOk) begin
            nextState = ST_FETCH_HI;
          end else begin
            strb.latchRd = 1'b1;
            strb.consume = (regAddr == DATA_ADDR) && cmdValid;
            nextState    = ST_ACK;
          end
        end
      end
      ST_FETCH_HI: begin
        strb.fetchHi = 1'b1;
        nextState    = ST_FETCH_LO;
      end
      ST_FETCH_LO: begin
        strb.fetchLo = 1'b1;
        strb.consume = 1'b1;
        nextState    = ST_ACK;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign regReady = (state == ST_ACK);

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    regReady |=> !regReady); // R10
  AST_FETCH_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && regRdEn && !regWrEn && regAddr == DATA_ADDR && !cardOk) |=> state == ST_ACK); // R7
endmodule

// File: rtl/mb_datapath.sv
module mb_datapath
  import mb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  mbStrobe_t            strb,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_CARDS-1:0] slotPresent,
  input  logic [NUM_CARDS-1:0] cardHasEeprom,
  input  logic [BYTE_W-1:0]    eeData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 cmdValid,
  output logic                 cardOk,
  output logic                 eeReq,
  output logic [CARD_W-1:0]    eeCard,
  output logic [OFF_W-1:0]     eeAddr
);
  logic [DATA_W-1:0]    selReg;
  logic [OFF_W-1:0]     offset;
  logic                 cmdPtr;
  logic [NUM_CARDS-1:0] codeHit;
  logic [CARD_W-1:0]    cardIdx;

  for (genvar c = 0; c < NUM_CARDS; c++) begin : g_code
    assign codeHit[c] = (selReg == CARD_CODE[c]);
  end

  always_comb begin
    cardIdx = '0;
    for (int c = 0; c < NUM_CARDS; c++)
      if (codeHit[c]) cardIdx = CARD_W'(c);
  end

  assign cardOk = |(codeHit & cardHasEeprom);
  assign eeReq  = strb.fetchHi | strb.fetchLo;
  assign eeCard = cardIdx;
  assign eeAddr = strb.fetchLo ? offset + OFF_W'(1) : offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selReg   <= '0;
      offset   <= '0;
      cmdPtr   <= 1'b0;
      cmdValid <= 1'b0;
    end else begin
      if (strb.selWr) selReg <= regWrData;
      if (strb.cmdWr) begin
        if (!cmdPtr) offset <= regWrData[OFF_W-1:0];
        else         cmdValid <= 1'b1;
        cmdPtr <= ~cmdPtr;
      end else if (strb.consume) begin
        cmdValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regRdData <= '0;
    end else if (strb.latchRd) begin
      if (regAddr == SEL_ADDR)       regRdData <= BLANK & ~DATA_W'(slotPresent);
      else if (regAddr == ID_ADDR)   regRdData <= ID_VALUE;
      else if (regAddr == DATA_ADDR) regRdData <= BLANK;
      else                           regRdData <= '0;
    end else if (strb.fetchHi) begin
      regRdData[DATA_W-1:BYTE_W] <= eeData;
    end else if (strb.fetchLo) begin
      regRdData[BYTE_W-1:0] <= eeData;
    end
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fetchHi |=> (strb.fetchLo && eeAddr == $past(eeAddr) + OFF_W'(1))); // R5
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.consume && !strb.cmdWr) |=> !cmdValid); // R6
  AST_ARM_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdValid) |-> $past(strb.cmdWr)); // R3
  AST_SEL_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    strb.selWr |=> $stable(cmdPtr)); // R9
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchRd && regAddr == ID_ADDR) |=> regRdData == 16'h0004); // R8
endmodule

// File: rtl/eeprom_mailbox.sv
module eeprom_mailbox
  import mb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 regReady,
  input  logic [NUM_CARDS-1:0] slotPresent,
  input  logic [NUM_CARDS-1:0] cardHasEeprom,
  output logic                 eeReq,
  output logic [CARD_W-1:0]    eeCard,
  output logic [OFF_W-1:0]     eeAddr,
  input  logic [BYTE_W-1:0]    eeData
);
  mbStrobe_t strb;
  logic      cmdValid;
  logic      cardOk;

  mb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .cmdValid(cmdValid), .cardOk(cardOk),
    .strb(strb), .regReady(regReady)
  );

  mb_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .slotPresent(slotPresent),
    .cardHasEeprom(cardHasEeprom), .eeData(eeData), .regRdData(regRdData),
    .cmdValid(cmdValid), .cardOk(cardOk), .eeReq(eeReq), .eeCard(eeCard),
    .eeAddr(eeAddr)
  );
endmodule

// File: tb/eeprom_mailbox_test.sv
module eeprom_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        regReady;
  logic [2:0]  slotPresent = 3'b000;
  logic [2:0]  cardHasEeprom = 3'b111;
  logic        eeReq;
  logic [1:0]  eeCard;
  logic [5:0]  eeAddr;
  logic [7:0]  eeData;

  int vectors = 0;
  int fails = 0;
  int cycle = 0;

  // model state
  logic [15:0] mSel = '0;
  logic [15:0] mCmd[$];
  logic [5:0]  mOff = '0;
  bit          mArmed = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] romByte(int card, int a);
    return 8'((card * 64 + a) * 7 + 3);
  endfunction

  assign eeData = romByte(int'(eeCard), int'(eeAddr));

  eeprom_mailbox uut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .regReady(regReady), .slotPresent(slotPresent),
    .cardHasEeprom(cardHasEeprom), .eeReq(eeReq), .eeCard(eeCard),
    .eeAddr(eeAddr), .eeData(eeData)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int cardOf(logic [15:0] s);
    if (s == 16'h1700) return 0;
    if (s == 16'h1D00) return 1;
    if (s == 16'h3500) return 2;
    return -1;
  endfunction

  // model-side bookkeeping of a write (R3, R4, R9, R11)
  task automatic modelWrite(logic [23:0] a, logic [15:0] d);
    if (a == 24'h100004) mSel = d;
    else if (a == 24'h100008) begin
      mCmd.push_back(d);
      if (mCmd.size() == 2) begin
        mOff = mCmd[0][5:0];
        mCmd.delete();
        mArmed = 1;
      end
    end
  endtask

  task automatic access(bit wr, logic [23:0] a, logic [15:0] d, string tag);
    int lat;
    logic [15:0] exp;
    int card;
    int n;
    lat = 1;
    exp = 16'h0000;
    if (wr) modelWrite(a, d);
    else if (a == 24'h100004) exp = 16'hFFFF & ~{13'd0, slotPresent};
    else if (a == 24'h100006) exp = 16'h0004;
    else if (a == 24'h100008) begin
      exp = 16'hFFFF;
      if (mArmed) begin
        card = cardOf(mSel);
        if (card >= 0 && cardHasEeprom[card]) begin
          exp = {romByte(card, int'(mOff)), romByte(card, int'(6'(mOff + 6'd1)))};
          lat = 3;
        end
        mArmed = 0;
      end
    end
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = wr; regRdEn = !wr;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      check({tag, " R10 ready"}, {15'd0, regReady}, {15'd0, n == lat});
      if (regReady || n > 8) break;
    end
    if (!wr && regReady) check(tag, regRdData, exp);
    regWrEn = 0; regRdEn = 0;
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset R10 ready low", {15'd0, regReady}, 16'd0);
    check("reset eeReq low", {15'd0, eeReq}, 16'd0);
    rst_n = 1;
    access(0, 24'h100006, 0, "R8 id");
    slotPresent = 3'b101;
    access(0, 24'h100004, 0, "R1 presence 101");
    slotPresent = 3'b010;
    access(0, 24'h100004, 0, "R1 presence 010");
    access(0, 24'h100008, 0, "R7 no command");
    access(1, 24'h100004, 16'h1700, "R1 select card0");
    access(1, 24'h100008, 16'h0185, "R3 word0");
    access(1, 24'h100008, 16'h0000, "R3 word1");
    access(0, 24'h100008, 0, "R5 card0 offset5");
    access(0, 24'h100008, 0, "R6 one-shot");
    access(1, 24'h100004, 16'h1D00, "R2 select card1");
    access(1, 24'h100008, 16'h01BF, "R5 word0");
    access(1, 24'h100008, 16'h0000, "R5 word1");
    access(0, 24'h100008, 0, "R5 wrap 63");
    access(1, 24'h100008, 16'h0190, "R9 word0");
    access(1, 24'h100004, 16'h3500, "R9 select mid");
    access(1, 24'h100008, 16'h0000, "R9 word1");
    access(0, 24'h100008, 0, "R9 R2 card2");
    access(1, 24'h100008, 16'hFFC5, "R4 word0");
    access(1, 24'h100008, 16'hABCD, "R4 word1");
    access(0, 24'h100008, 0, "R4 offset bits");
    cardHasEeprom = 3'b011;
    access(1, 24'h100008, 16'h0181, "R7 word0");
    access(1, 24'h100008, 16'h0000, "R7 word1");
    access(0, 24'h100008, 0, "R7 absent eeprom");
    cardHasEeprom = 3'b111;
    access(0, 24'h100008, 0, "R6 R7 consumed");
    access(1, 24'h100004, 16'h1234, "R2 bad select");
    access(1, 24'h100008, 16'h0182, "R2 word0");
    access(1, 24'h100008, 16'h0000, "R2 word1");
    access(0, 24'h100008, 0, "R2 no card");
    access(1, 24'h100010, 16'h3500, "R11 unmapped write");
    access(0, 24'h100010, 0, "R11 unmapped read");
    access(0, 24'h100004, 0, "R11 select kept");
    access(1, 24'h100004, 16'h1700, "R11 reselect");
    access(1, 24'h100008, 16'h0180, "R11 word0");
    access(1, 24'h100008, 16'h0000, "R11 word1");
    access(0, 24'h100008, 0, "R11 card0 offset0");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule